// File: doc/BRIEF.md
# System Control Register Block

This block is the memory-mapped control register file of a small two-core microcontroller subsystem. A simple 32-bit peripheral bus gives it a word address, a write strobe and write data, and it returns read data combinationally for the addressed word. Inside it keeps the cause of the last reset, a reset mask, a retention word, a secure debug status word, one initial vector table offset per core and a per-core wait mask. From these it drives a one-cycle system reset request and one-cycle power-up-and-reset pulses, one for each core.

A version input selects the variant. When the variant is extended, it also maps a security control word, two clock divider words, a clock force word, the second vector offset, an external wake control word and five power-domain sense words. In the base variant these offsets act as unmapped. The block does not divide clocks, gate power or sequence resets. It only holds the values and pulses that other logic uses for those tasks.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, these offsets read as follows: 0x100 (reset cause) reads 1, 0x110 and 0x114 (vector offsets) read the parameters VTOR0_RST and VTOR1_RST (default 0x1000_0000), and 0x118 (wait) reads WAIT_RST (default 0). In the extended variant 0x200 reads 0x7F. Every other register reads 0, and both pulse outputs are low.
- R2: A write to 0x4 ORs the data into the debug status. A write to 0x8 clears each status bit whose data bit is 1. Offset 0x0 reads the status, and writes to 0x0 change nothing.
- R3: A write to 0x108 with data bit 9 set raises sys_reset_req_o for exactly the one cycle after the write edge. A write to 0x108 with bit 9 clear leaves it low.
- R4: Offsets 0x4, 0x8 and 0x108 always read zero.
- R5: Offset 0x118 is a 32-bit read/write word. Its bit 0 drives core_wait_o[0] and its bit 1 drives core_wait_o[1].
- R6: A write to 0x118 that takes bit i from 1 to 0 raises core_powerup_o[i] for exactly the one cycle after the write edge. The written value is stored in the same edge.
- R7: Writes to 0x110 update core_vtor_o[0]. In the extended variant, writes to 0x114 update core_vtor_o[1].
- R8: The variant is extended exactly when version_i[31:28] equals 2. It is evaluated on every access.
- R9: Offsets 0xC, 0x10, 0x14, 0x18, 0x114, 0x124, 0x200 and 0x20C–0x218 are read/write in the extended variant. In the base variant they read zero, and writes to them leave the stored state unchanged (core_vtor_o[1] keeps its value).
- R10: Offset 0x11C is read/write in the extended variant. In the base variant it reads zero and ignores writes.
- R11: Offsets 0x100, 0x104, 0x10C and 0x120 are read/write in both variants. Reads are combinational from the address, and a write is visible after its clock edge.
- R12: Offsets 0xFD0 to 0xFFC read, in rising address order, the low bytes 0x04, 0x00, 0x00, 0x00, 0x54, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05 and 0xB1 with zero upper bits. Writes to these offsets are ignored.
- R13: Address bits 1:0 are ignored, so a narrow access acts on its containing word. Unmapped offsets read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| version_i | input | 32 | Version word; the top nibble selects the variant |
| bus_addr_i | input | 12 | Byte offset of the access |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data, zero-padded for narrow writes |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| sys_reset_req_o | output | 1 | One-cycle system reset request |
| core_powerup_o | output | 2 | One-cycle power-up-and-reset pulse per core |
| core_wait_o | output | 2 | Per-core wait bits |
| core_vtor_o | output | 2x32 | Per-core initial vector table offset |

## Verification
Directed sequences run under both variants. Debug set and clear writes use overlapping masks, which separates an OR from an overwrite and a clear-on-one from a clear-on-zero. The wait word is written 3→2→0→0 and then 3→0. These sequences separate a falling-edge detector from a level or rising detector, and single-core pulses from paired ones. Writes with and without bit 9 at 0x108, and writes to the hidden offsets in the base variant, confirm that only the named bit or variant has an effect. After these, a long stream of mixed reads and writes over every mapped, hidden and unaligned offset is compared against the behavioural model on every cycle.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int NCORE     = 2;
  localparam int WORD_W    = 32;
  localparam int OFS_W     = 12;
  localparam int IDX_W     = OFS_W - 2;
  localparam int SWRST_BIT = 9;
  localparam int ID_BASE   = 'h3F4;
  localparam int NREG      = 19;
  localparam logic [3:0] EXT_CODE = 4'd2;

  typedef enum logic [4:0] {
    RG_DBG, RG_SECCTL, RG_FDIV, RG_SDIV, RG_CFORCE, RG_RSYN, RG_RMASK,
    RG_GRET, RG_VTOR0, RG_VTOR1, RG_CWAIT, RG_NMI, RG_WIC, RG_EWC,
    RG_PDSYS, RG_PDS0, RG_PDS1, RG_PDS2, RG_PDS3, RG_NONE
  } reg_e;

  typedef enum logic [2:0] {
    AC_NONE, AC_RW, AC_RO, AC_SET, AC_CLR, AC_PULSE, AC_ID
  } acc_e;

  typedef struct packed {
    reg_e id;
    acc_e acc;
  } hit_t;

  function automatic logic variant_ext(input logic [WORD_W-1:0] ver);
    return ver[WORD_W-1 -: 4] == EXT_CODE;
  endfunction

  function automatic logic [7:0] id_byte(input logic [3:0] k);
    case (k)
      4'd0:  return 8'h04;
      4'd4:  return 8'h54;
      4'd5:  return 8'hB8;
      4'd6:  return 8'h0B;
      4'd8:  return 8'h0D;
      4'd9:  return 8'hF0;
      4'd10: return 8'h05;
      4'd11: return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

  function automatic hit_t ext_only(input reg_e id, input logic ext);
    hit_t h;
    h.id  = ext ? id : RG_NONE;
    h.acc = ext ? AC_RW : AC_NONE;
    return h;
  endfunction

  function automatic hit_t decode(input logic [IDX_W-1:0] w, input logic ext);
    hit_t h;
    h.id  = RG_NONE;
    h.acc = AC_NONE;
    case (int'(w))
      'h000: begin h.id = RG_DBG; h.acc = AC_RO;  end
      'h001: begin h.id = RG_DBG; h.acc = AC_SET; end
      'h002: begin h.id = RG_DBG; h.acc = AC_CLR; end
      'h003: h = ext_only(RG_SECCTL, ext);
      'h004: h = ext_only(RG_FDIV, ext);
      'h005: h = ext_only(RG_SDIV, ext);
      'h006: h = ext_only(RG_CFORCE, ext);
      'h040: begin h.id = RG_RSYN;  h.acc = AC_RW; end
      'h041: begin h.id = RG_RMASK; h.acc = AC_RW; end
      'h042: h.acc = AC_PULSE;
      'h043: begin h.id = RG_GRET;  h.acc = AC_RW; end
      'h044: begin h.id = RG_VTOR0; h.acc = AC_RW; end
      'h045: h = ext_only(RG_VTOR1, ext);
      'h046: begin h.id = RG_CWAIT; h.acc = AC_RW; end
      'h047: h = ext_only(RG_NMI, ext);
      'h048: begin h.id = RG_WIC;   h.acc = AC_RW; end
      'h049: h = ext_only(RG_EWC, ext);
      'h080: h = ext_only(RG_PDSYS, ext);
      'h083: h = ext_only(RG_PDS0, ext);
      'h084: h = ext_only(RG_PDS1, ext);
      'h085: h = ext_only(RG_PDS2, ext);
      'h086: h = ext_only(RG_PDS3, ext);
      default: if (int'(w) >= ID_BASE) h.acc = AC_ID;
    endcase
    return h;
  endfunction

  function automatic logic [WORD_W-1:0] rst_value(input reg_e id,
      input logic [WORD_W-1:0] vt0, input logic [WORD_W-1:0] vt1,
      input logic [WORD_W-1:0] cw);
    case (id)
      RG_RSYN:  return 32'h1;
      RG_PDSYS: return 32'h7F;
      RG_VTOR0: return vt0;
      RG_VTOR1: return vt1;
      RG_CWAIT: return cw;
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
(
  input  logic [WORD_W-1:0] version_i,
  input  logic [OFS_W-1:0]  addr_i,
  output logic              ext_o,
  output hit_t              hit_o
);
  assign ext_o = variant_ext(version_i);
  assign hit_o = decode(addr_i[OFS_W-1:2], ext_o);
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter logic [WORD_W-1:0] VTOR0_RST = 32'h1000_0000,
  parameter logic [WORD_W-1:0] VTOR1_RST = 32'h1000_0000,
  parameter logic [WORD_W-1:0] WAIT_RST  = 32'h0
)(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  hit_t                         hit,
  input  logic [WORD_W-1:0]            wdata,
  output logic [NREG-1:0][WORD_W-1:0]  regs
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[g] <= rst_value(reg_e'(g), VTOR0_RST, VTOR1_RST, WAIT_RST);
      end else if (wr_en && hit.id == reg_e'(g)) begin
        case (hit.acc)
          AC_RW:   regs[g] <= wdata;
          AC_SET:  regs[g] <= regs[g] | wdata;
          AC_CLR:  regs[g] <= regs[g] & ~wdata;
          default: regs[g] <= regs[g];
        endcase
      end
    end
  end

  // R2
  dbg_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit.acc == AC_SET) |=> ((regs[RG_DBG] & $past(wdata)) == $past(wdata)));
  // R2
  dbg_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit.acc == AC_CLR) |=> ((regs[RG_DBG] & $past(wdata)) == '0));
  // R13
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (hit.acc == AC_NONE || hit.acc == AC_ID || hit.acc == AC_RO
               || hit.acc == AC_PULSE)) |=> $stable(regs));
endmodule

// File: rtl/sysctl_wake.sv
module sysctl_wake
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_wr,
  input  logic [NCORE-1:0] cur_bits,
  input  logic [NCORE-1:0] new_bits,
  output logic [NCORE-1:0] pulse_o
);
  logic [NCORE-1:0] fall_w;

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    assign fall_w[c] = wait_wr && cur_bits[c] && !new_bits[c];

    always_ff @(posedge clk) begin
      if (!rst_n) pulse_o[c] <= 1'b0;
      else        pulse_o[c] <= fall_w[c];
    end

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o[c] |=> !pulse_o[c]);
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter logic [31:0] VTOR0_RST = 32'h1000_0000,
  parameter logic [31:0] VTOR1_RST = 32'h1000_0000,
  parameter logic [31:0] WAIT_RST  = 32'h0
)(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [WORD_W-1:0]            version_i,
  input  logic [OFS_W-1:0]             bus_addr_i,
  input  logic                         bus_we_i,
  input  logic [WORD_W-1:0]            bus_wdata_i,
  output logic [WORD_W-1:0]            bus_rdata_o,
  output logic                         sys_reset_req_o,
  output logic [NCORE-1:0]             core_powerup_o,
  output logic [NCORE-1:0]             core_wait_o,
  output logic [NCORE-1:0][WORD_W-1:0] core_vtor_o
);
  logic                        ext_w;
  hit_t                        hit_w;
  logic [NREG-1:0][WORD_W-1:0] regs_w;
  logic                        swrst_fire_w;
  logic                        wait_wr_w;

  sysctl_decode u_dec (
    .version_i (version_i),
    .addr_i    (bus_addr_i),
    .ext_o     (ext_w),
    .hit_o     (hit_w)
  );

  sysctl_regfile #(
    .VTOR0_RST (VTOR0_RST),
    .VTOR1_RST (VTOR1_RST),
    .WAIT_RST  (WAIT_RST)
  ) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (bus_we_i),
    .hit   (hit_w),
    .wdata (bus_wdata_i),
    .regs  (regs_w)
  );

  assign wait_wr_w = bus_we_i && hit_w.id == RG_CWAIT && hit_w.acc == AC_RW;

  sysctl_wake u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .wait_wr  (wait_wr_w),
    .cur_bits (regs_w[RG_CWAIT][NCORE-1:0]),
    .new_bits (bus_wdata_i[NCORE-1:0]),
    .pulse_o  (core_powerup_o)
  );

  assign swrst_fire_w = bus_we_i && hit_w.acc == AC_PULSE && bus_wdata_i[SWRST_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) sys_reset_req_o <= 1'b0;
    else        sys_reset_req_o <= swrst_fire_w;
  end

  always_comb begin
    bus_rdata_o = '0;
    case (hit_w.acc)
      AC_RW, AC_RO: if (hit_w.id != RG_NONE) bus_rdata_o = regs_w[int'(hit_w.id)];
      AC_ID: bus_rdata_o = {24'b0, id_byte(4'(int'(bus_addr_i[OFS_W-1:2]) - ID_BASE))};
      default: bus_rdata_o = '0;
    endcase
  end

  assign core_wait_o    = regs_w[RG_CWAIT][NCORE-1:0];
  assign core_vtor_o[0] = regs_w[RG_VTOR0];
  assign core_vtor_o[1] = regs_w[RG_VTOR1];

  // R3
  swrst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req_o |-> ($past(bus_we_i) && $past(bus_wdata_i[SWRST_BIT])));
  // R3
  swrst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_fire_w |=> sys_reset_req_o);
  // R9
  base_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (version_i[31:28] != 4'd2 && bus_addr_i[11:2] == 10'h080) |-> bus_rdata_o == '0);
  // R4
  wo_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i[11:2] == 10'h042) |-> bus_rdata_o == '0);

  for (genvar c = 0; c < NCORE; c++) begin : g_pu_chk
    // R6
    powerup_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_powerup_o[c] |-> ($past(core_wait_o[c]) && !core_wait_o[c]));
  end
endmodule

// File: tb/sysctl_regs_bench.sv
module sysctl_regs_bench;
  localparam int CLK_P = 10;
  localparam logic [31:0] VT0 = 32'h1000_0000;
  localparam logic [31:0] VT1 = 32'h1000_0000;
  localparam logic [31:0] WRST = 32'h0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] version = 32'h1000_0000;
  logic [11:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic sys_rst;
  logic [1:0] pu;
  logic [1:0] cwait;
  logic [1:0][31:0] vtor;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] st [int];
  bit ext_m = 0;
  bit exp_rst = 0;
  logic [1:0] exp_pu = '0;

  always #(CLK_P/2) clk = ~clk;

  sysctl_regs #(.VTOR0_RST(VT0), .VTOR1_RST(VT1), .WAIT_RST(WRST)) u_sysctl_regs (
    .clk(clk), .rst_n(rst_n), .version_i(version), .bus_addr_i(bus_addr),
    .bus_we_i(bus_we), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .sys_reset_req_o(sys_rst), .core_powerup_o(pu), .core_wait_o(cwait),
    .core_vtor_o(vtor)
  );

  function automatic bit is_plain(int w);
    return w == 'h100 || w == 'h104 || w == 'h10C || w == 'h110 || w == 'h118 || w == 'h120;
  endfunction

  function automatic bit is_ext(int w);
    return w == 'hC || w == 'h10 || w == 'h14 || w == 'h18 || w == 'h114 || w == 'h124
        || w == 'h11C || w == 'h200 || (w >= 'h20C && w <= 'h218);
  endfunction

  function automatic logic [31:0] id_val(int k);
    logic [7:0] t [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h54, 8'hB8,
                           8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return {24'b0, t[k]};
  endfunction

  function automatic logic [31:0] mread(logic [11:0] a);
    int w = int'(a) & 'hFFC;
    if (w == 0) return st[0];
    if (is_plain(w)) return st[w];
    if (is_ext(w)) return ext_m ? st[w] : 32'h0;
    if (w >= 'hFD0) return id_val((w - 'hFD0) / 4);
    return 32'h0;
  endfunction

  task automatic model_init();
    int keys [] = '{0, 'hC, 'h10, 'h14, 'h18, 'h100, 'h104, 'h10C, 'h110, 'h114,
                    'h118, 'h11C, 'h120, 'h124, 'h200, 'h20C, 'h210, 'h214, 'h218};
    foreach (keys[i]) st[keys[i]] = 32'h0;
    st['h100] = 32'h1;
    st['h200] = 32'h7F;
    st['h110] = VT0;
    st['h114] = VT1;
    st['h118] = WRST;
    exp_rst = 0;
    exp_pu = '0;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic [31:0] ver);
    @(negedge clk);
    rst_n = 1'b0; version = ver; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    ext_m = (ver[31:28] == 4'd2);
    model_init();
    rst_n = 1'b1;
  endtask

  task automatic cyc(logic [11:0] a, logic we, logic [31:0] d, string tag);
    int w;
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = d;
    #1;
    chk(tag, bus_rdata, mread(a));
    chk("R3 reset pulse", {31'b0, sys_rst}, {31'b0, exp_rst});
    chk("R6 powerup pulse", {30'b0, pu}, {30'b0, exp_pu});
    chk("R5 wait out", {30'b0, cwait}, {30'b0, st['h118][1:0]});
    chk("R7 vtor0 out", vtor[0], st['h110]);
    chk("R7 vtor1 out", vtor[1], st['h114]);
    w = int'(a) & 'hFFC;
    exp_rst = we && w == 'h108 && d[9];
    exp_pu = '0;
    if (we) begin
      if (w == 'h4) st[0] = st[0] | d;
      else if (w == 'h8) st[0] = st[0] & ~d;
      else if (is_plain(w) || (is_ext(w) && ext_m)) begin
        if (w == 'h118) exp_pu = st['h118][1:0] & ~d[1:0];
        st[w] = d;
      end
    end
  endtask

  task automatic rd(logic [11:0] a, string tag);
    cyc(a, 1'b0, 32'h0, tag);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
    cyc(a, 1'b1, d, tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int offs [] = '{'h0, 'h4, 'h8, 'hC, 'h10, 'h14, 'h18, 'h100, 'h104, 'h108,
                    'h10C, 'h110, 'h114, 'h118, 'h11C, 'h120, 'h124, 'h200,
                    'h20C, 'h210, 'h214, 'h218, 'h300, 'hFD8, 'hFFC, 'h10E, 'h119};
    // Base variant
    do_reset(32'h1000_0000);
    rd(12'h100, "R1 syndrome"); rd(12'h110, "R1 vtor0"); rd(12'h114, "R1 base vtor1");
    rd(12'h118, "R1 wait"); rd(12'h000, "R1 dbg"); rd(12'h200, "R9 base pdsys");
    for (int k = 0; k < 12; k++) rd(12'(12'hFD0 + 4 * k), "R12 id");
    wr(12'hFE0, 32'hFFFF_FFFF, "R12 id write"); rd(12'hFE0, "R12 id after write");
    wr(12'h004, 32'h0000_00A5, "R2 set"); wr(12'h004, 32'h0000_0F00, "R2 set");
    wr(12'h008, 32'h0000_0105, "R2 clear"); rd(12'h000, "R2 status");
    wr(12'h000, 32'hFFFF_FFFF, "R2 ro write"); rd(12'h000, "R2 status kept");
    rd(12'h004, "R4 set reads 0"); rd(12'h008, "R4 clr reads 0"); rd(12'h108, "R4 swrst reads 0");
    wr(12'h108, 32'h0000_0200, "R3 swrst"); rd(12'h0, "R3 after");
    wr(12'h108, 32'hFFFF_FDFF, "R3 other bits"); rd(12'h0, "R3 none");
    wr(12'h118, 32'h3, "R5 wait"); wr(12'h118, 32'h2, "R6 fall core0");
    wr(12'h118, 32'h0, "R6 fall core1"); wr(12'h118, 32'h0, "R6 no fall");
    wr(12'h118, 32'h3, "R6 set both"); wr(12'h118, 32'h0, "R6 both fall");
    rd(12'h118, "R5 read");
    wr(12'h110, 32'h2000_0400, "R7 vtor0"); rd(12'h110, "R7 vtor0 read");
    wr(12'h114, 32'h3000_0000, "R9 base vtor1 ignored"); rd(12'h114, "R9 base vtor1");
    wr(12'h010, 32'h1234_5678, "R9 base div"); rd(12'h010, "R9 base div read");
    wr(12'h11C, 32'h1, "R10 base nmi"); rd(12'h11C, "R10 base nmi read");
    wr(12'h10E, 32'hCAFE_0001, "R13 unaligned"); rd(12'h10C, "R13 aligned read");
    wr(12'h104, 32'h0000_00F0, "R11 mask"); rd(12'h105, "R11 mask read");
    wr(12'h300, 32'hFFFF_FFFF, "R13 unmapped"); rd(12'h300, "R13 unmapped read");
    rd(12'h120, "R11 wic");
    // Extended variant
    do_reset(32'h2000_0001);
    rd(12'h200, "R1 pdsys"); rd(12'h114, "R1 vtor1"); rd(12'h010, "R1 div");
    wr(12'h114, 32'h3000_0100, "R7 vtor1"); rd(12'h114, "R8 vtor1 read");
    wr(12'h11C, 32'h1, "R10 ext nmi"); rd(12'h11C, "R10 ext nmi read");
    wr(12'h218, 32'hA5A5_0000, "R9 pd3"); rd(12'h218, "R9 pd3 read");
    wr(12'h00C, 32'h7, "R9 secctl"); rd(12'h00C, "R9 secctl read");
    for (int n = 0; n < 600; n++) begin
      int o = offs[$urandom_range(0, offs.size() - 1)];
      if (n == 300) begin
        @(negedge clk); version = 32'h1FFF_0000; ext_m = 0;
      end
      cyc(12'(o), 1'($urandom_range(0, 1)), $urandom, "R8 mixed");
    end
    rd(12'h0, "R13 final");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule